// File: doc/BRIEF.md
# Latency-Class-Aware LRU Set Manager

This block keeps the replacement state of one set of an eight-way cache. The ways of the set fall into two latency classes: quick ways and slow ways. The class of each way is given by a static per-way mask. The block holds a full recency ordering of the ways. For every access it returns one response. A response can name the way that receives new data, the way whose content leaves the set, and up to two data-movement commands for the array controller. The tag array and the data path are outside the block.

The policy steers recently used content toward the quick ways, and it does this only while lines are being replaced. A hit updates the ordering and nothing else. While empty ways remain, a miss fills them in a fixed order. After the set is full, a miss that evicts a line from a slow way first moves the oldest quick-way line into the freed slow slot, so that the new line can land in a quick way. Any replacement can then add one swap. That swap brings the second most recent line into the quick class if it sits in a slow way. A recency value always follows its data when that data moves.

Top module: `vlru_set`

## Requirements
- R1: After reset all ways are empty and every response output is low. The first miss then fills the lowest-index quick way, or way 0 if there is no quick way.
- R2: While an empty way exists, a miss fills the lowest-index empty quick way. If no empty quick way is left, it fills the lowest-index empty slow way. Such a fill raises fillValid with no eviction and no movement command.
- R3: Each way holds a recency rank from 0 (oldest) to 7 (newest). A hit on a valid way, or a fill, makes that way rank 7. Every valid line ranked above the touched line's old rank drops by one. On a fill into an empty way, every valid line drops by one.
- R4: A hit response has fillValid, evictValid and both command valids low. A hit on an empty way changes no state.
- R5: A miss in a full set evicts the rank-0 way. evictValid is high and evictWay names that way. If that way is quick, or migration is off, fillWay equals evictWay and no move is issued.
- R6: If the rank-0 way of a full set is slow and migration is on, the block issues the first command (mig0): source is the lowest-ranked quick way, destination is the rank-0 way. fillWay is then that source way.
- R7: After any full-set replacement with migration on, consider the line that now has rank 6. If it is in a slow way, and the lowest-ranked quick way does not hold the new line, the block issues the second command (mig1): a swap with source the slow way and destination that quick way.
- R8: When the class mask is all zeros or all ones, no command is ever issued and the block acts as plain LRU.
- R9: The response appears on the outputs in the cycle after accValid is sampled. rspValid is high for exactly that cycle. Every way field whose valid flag is low reads 0, and with no access all flags are low.
- R10: A moved or swapped line keeps its rank. Later victims follow the recency of the data, not of the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accHit | input | 1 | 1 = hit on hitWay, 0 = miss needing a fill |
| hitWay | input | 3 | Way that hit |
| fastMask | input | 8 | Bit i set means way i is a quick way |
| rspValid | output | 1 | Response for the previous cycle's access |
| fillValid | output | 1 | New data must be written |
| fillWay | output | 3 | Way that receives new data |
| evictValid | output | 1 | A line leaves the set |
| evictWay | output | 3 | Way of the evicted line |
| mig0Valid | output | 1 | Move command present |
| mig0Src | output | 3 | Move source way (quick) |
| mig0Dst | output | 3 | Move destination way (slow victim) |
| mig1Valid | output | 1 | Swap command present |
| mig1Src | output | 3 | Swap way in the slow class |
| mig1Dst | output | 3 | Swap way in the quick class |

## Verification
A corrupted rank or valid bit does not show at the ports right away. It appears at the next full-set miss, which then names the wrong evictWay, the wrong move source or a missing swap. That can take up to eight accesses after the fault, so long random sequences with many replacements follow the directed fills. A wrong class decision shows in the same response cycle as a command whose source or destination class is inconsistent with the mask.

// File: rtl/vlru_pkg.sv
`timescale 1ns/1ps
package vlru_pkg;
  parameter int unsigned WAYS = 8;
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [WAY_W-1:0] RANK_MRU = WAY_W'(WAYS - 1);
  localparam logic [WAY_W-1:0] RANK_NEXT = WAY_W'(WAYS - 2);

  typedef logic [WAY_W-1:0] way_t;
  typedef logic [WAYS-1:0][WAY_W-1:0] rankVec_t;

  // strobes from the decision logic to the state/response registers
  typedef struct packed {
    logic respond;
    logic touch;
    logic fresh;
    logic isMiss;
    way_t touchWay;
    logic evict;
    way_t evictWay;
    logic move;
    way_t moveSrc;
    way_t moveDst;
    logic swap;
    way_t swapSlow;
    way_t swapFast;
  } strobes_t;

  // rank state after the optional move and the touch of the target way
  function automatic rankVec_t moveAndTouch(rankVec_t r, logic [WAYS-1:0] v, strobes_t s);
    rankVec_t o;
    way_t base;
    o = r;
    base = r[s.touchWay];
    if (s.move) begin
      o[s.moveDst] = r[s.moveSrc];
      base = r[s.moveDst];
    end
    if (s.touch) begin
      for (int i = 0; i < WAYS; i++) begin
        if (v[i] && (way_t'(i) != s.touchWay) && (s.fresh || (o[i] > base)))
          o[i] = o[i] - way_t'(1);
      end
      o[s.touchWay] = RANK_MRU;
    end
    return o;
  endfunction
endpackage

// File: rtl/vlru_ctrl.sv
`timescale 1ns/1ps
module vlru_ctrl
  import vlru_pkg::*;
(
  input  logic            accValid,
  input  logic            accHit,
  input  way_t            hitWay,
  input  logic [WAYS-1:0] fastMask,
  input  rankVec_t        rank,
  input  logic [WAYS-1:0] valid,
  output strobes_t        strb
);
  function automatic way_t lowestQuick(rankVec_t r, logic [WAYS-1:0] m);
    way_t best;
    way_t bestRank;
    best = '0;
    bestRank = RANK_MRU;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (m[i] && (r[i] <= bestRank)) begin
        best = way_t'(i);
        bestRank = r[i];
      end
    end
    return best;
  endfunction

  logic     migEn, full, haveFreeQuick;
  way_t     freeQuick, freeSlow, victim, oldQuick, secondWay, midQuick;
  strobes_t core;
  rankVec_t mid;

  assign migEn = (|fastMask) && !(&fastMask);
  assign full  = &valid;

  always_comb begin
    freeQuick = '0;
    freeSlow  = '0;
    haveFreeQuick = 1'b0;
    victim = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid[i] && fastMask[i]) begin
        freeQuick = way_t'(i);
        haveFreeQuick = 1'b1;
      end
      if (!valid[i] && !fastMask[i]) freeSlow = way_t'(i);
      if (valid[i] && (rank[i] == '0)) victim = way_t'(i);
    end
  end

  assign oldQuick = lowestQuick(rank, fastMask);

  always_comb begin
    core = '0;
    core.respond = accValid;
    if (accValid) begin
      if (accHit) begin
        if (valid[hitWay]) begin
          core.touch = 1'b1;
          core.touchWay = hitWay;
        end
      end else if (!full) begin
        core.touch = 1'b1;
        core.fresh = 1'b1;
        core.isMiss = 1'b1;
        core.touchWay = haveFreeQuick ? freeQuick : freeSlow;
      end else begin
        core.touch = 1'b1;
        core.isMiss = 1'b1;
        core.evict = 1'b1;
        core.evictWay = victim;
        if (migEn && !fastMask[victim]) begin
          core.move = 1'b1;
          core.moveSrc = oldQuick;
          core.moveDst = victim;
          core.touchWay = oldQuick;
        end else begin
          core.touchWay = victim;
        end
      end
    end
  end

  assign mid = moveAndTouch(rank, valid, core);
  assign midQuick = lowestQuick(mid, fastMask);

  always_comb begin
    secondWay = '0;
    for (int i = 0; i < WAYS; i++)
      if (mid[i] == RANK_NEXT) secondWay = way_t'(i);
  end

  always_comb begin
    strb = core;
    if (core.evict && migEn && !fastMask[secondWay] && (midQuick != core.touchWay)) begin
      strb.swap = 1'b1;
      strb.swapSlow = secondWay;
      strb.swapFast = midQuick;
    end
  end
endmodule

// File: rtl/vlru_dp.sv
`timescale 1ns/1ps
module vlru_dp
  import vlru_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        strb,
  output rankVec_t        rank,
  output logic [WAYS-1:0] valid,
  output logic            rspValid,
  output logic            fillValid,
  output way_t            fillWay,
  output logic            evictValid,
  output way_t            evictWay,
  output logic            mig0Valid,
  output way_t            mig0Src,
  output way_t            mig0Dst,
  output logic            mig1Valid,
  output way_t            mig1Src,
  output way_t            mig1Dst
);
  rankVec_t nextRank;

  always_comb begin
    nextRank = moveAndTouch(rank, valid, strb);
    if (strb.swap) begin
      nextRank[strb.swapSlow] = nextRank[strb.swapFast];
      nextRank[strb.swapFast] = RANK_NEXT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rank       <= '0;
      valid      <= '0;
      rspValid   <= 1'b0;
      fillValid  <= 1'b0;
      fillWay    <= '0;
      evictValid <= 1'b0;
      evictWay   <= '0;
      mig0Valid  <= 1'b0;
      mig0Src    <= '0;
      mig0Dst    <= '0;
      mig1Valid  <= 1'b0;
      mig1Src    <= '0;
      mig1Dst    <= '0;
    end else begin
      rank <= nextRank;
      if (strb.touch) valid[strb.touchWay] <= 1'b1;
      rspValid   <= strb.respond;
      fillValid  <= strb.isMiss;
      fillWay    <= strb.isMiss ? strb.touchWay : '0;
      evictValid <= strb.evict;
      evictWay   <= strb.evictWay;
      mig0Valid  <= strb.move;
      mig0Src    <= strb.moveSrc;
      mig0Dst    <= strb.moveDst;
      mig1Valid  <= strb.swap;
      mig1Src    <= strb.swapSlow;
      mig1Dst    <= strb.swapFast;
    end
  end
endmodule

// File: rtl/vlru_set.sv
`timescale 1ns/1ps
module vlru_set
  import vlru_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            accValid,
  input  logic            accHit,
  input  way_t            hitWay,
  input  logic [WAYS-1:0] fastMask,
  output logic            rspValid,
  output logic            fillValid,
  output way_t            fillWay,
  output logic            evictValid,
  output way_t            evictWay,
  output logic            mig0Valid,
  output way_t            mig0Src,
  output way_t            mig0Dst,
  output logic            mig1Valid,
  output way_t            mig1Src,
  output way_t            mig1Dst
);
  strobes_t        strb;
  rankVec_t        rank;
  logic [WAYS-1:0] valid;

  vlru_ctrl u_ctrl (
    .accValid(accValid), .accHit(accHit), .hitWay(hitWay), .fastMask(fastMask),
    .rank(rank), .valid(valid), .strb(strb)
  );

  vlru_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rank(rank), .valid(valid),
    .rspValid(rspValid), .fillValid(fillValid), .fillWay(fillWay),
    .evictValid(evictValid), .evictWay(evictWay),
    .mig0Valid(mig0Valid), .mig0Src(mig0Src), .mig0Dst(mig0Dst),
    .mig1Valid(mig1Valid), .mig1Src(mig1Src), .mig1Dst(mig1Dst)
  );
endmodule

// File: rtl/vlru_checker.sv
`timescale 1ns/1ps
module vlru_checker
  import vlru_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            accHit,
  input logic [WAYS-1:0] fastMask,
  input logic            rspValid,
  input logic            fillValid,
  input way_t            fillWay,
  input logic            evictValid,
  input way_t            evictWay,
  input logic            mig0Valid,
  input way_t            mig0Src,
  input way_t            mig0Dst,
  input logic            mig1Valid,
  input way_t            mig1Src,
  input way_t            mig1Dst
);
  logic [WAYS-1:0] pastMask;
  logic            pastHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pastMask <= '0;
      pastHit  <= 1'b0;
    end else begin
      pastMask <= fastMask;
      pastHit  <= accHit;
    end
  end

  AST_HIT_NO_MIGRATION: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && pastHit |-> !fillValid && !evictValid && !mig0Valid && !mig1Valid); // R4
  AST_FILL_NO_MIGRATION: assert property (@(posedge clk) disable iff (!rstN)
    fillValid && !evictValid |-> !mig0Valid && !mig1Valid); // R2
  AST_EVICT_HAS_FILL: assert property (@(posedge clk) disable iff (!rstN)
    evictValid |-> fillValid); // R5
  AST_MOVE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    mig0Valid |-> evictValid && (mig0Dst == evictWay) && (mig0Src == fillWay)
                  && pastMask[mig0Src] && !pastMask[mig0Dst]); // R6
  AST_SWAP_CLASSES: assert property (@(posedge clk) disable iff (!rstN)
    mig1Valid |-> evictValid && !pastMask[mig1Src] && pastMask[mig1Dst]
                  && (mig1Dst != fillWay)); // R7
  AST_UNIFORM_PLAIN: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && ((pastMask == '0) || (&pastMask)) |-> !mig0Valid && !mig1Valid); // R8
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !fillValid && !evictValid && !mig0Valid && !mig1Valid); // R9
endmodule

bind vlru_set vlru_checker u_chk (
  .clk(clk), .rstN(rstN), .accHit(accHit), .fastMask(fastMask),
  .rspValid(rspValid), .fillValid(fillValid), .fillWay(fillWay),
  .evictValid(evictValid), .evictWay(evictWay),
  .mig0Valid(mig0Valid), .mig0Src(mig0Src), .mig0Dst(mig0Dst),
  .mig1Valid(mig1Valid), .mig1Src(mig1Src), .mig1Dst(mig1Dst)
);

// File: tb/test_vlru_set.sv
`timescale 1ns/1ps
module test_vlru_set;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN, accValid, accHit;
  logic [2:0] hitWay;
  logic [7:0] fastMask;
  logic       rspValid, fillValid, evictValid, mig0Valid, mig1Valid;
  logic [2:0] fillWay, evictWay, mig0Src, mig0Dst, mig1Src, mig1Dst;

  vlru_set i_vlru_set (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accHit(accHit), .hitWay(hitWay),
    .fastMask(fastMask), .rspValid(rspValid), .fillValid(fillValid), .fillWay(fillWay),
    .evictValid(evictValid), .evictWay(evictWay), .mig0Valid(mig0Valid),
    .mig0Src(mig0Src), .mig0Dst(mig0Dst), .mig1Valid(mig1Valid),
    .mig1Src(mig1Src), .mig1Dst(mig1Dst)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // reference model: per-way last-use stamps, stamps travel with data
  int stamp[8];
  bit vld[8];
  int now;
  bit eFill, eEvict, eM0, eM1;
  int eFillWay, eEvictWay, eM0Src, eM0Dst, eM1Src, eM1Dst;
  string eTag;

  function automatic int quickOldest();
    int best = -1;
    for (int i = 0; i < 8; i++)
      if (fastMask[i] && vld[i] && (best < 0 || stamp[i] < stamp[best])) best = i;
    return best;
  endfunction

  function automatic void predict(bit hit, int way);
    bit isFull, migOn;
    int tgt, vic, sec, q, t;
    eFill = 0; eEvict = 0; eM0 = 0; eM1 = 0;
    eFillWay = 0; eEvictWay = 0; eM0Src = 0; eM0Dst = 0; eM1Src = 0; eM1Dst = 0;
    if (hit) begin
      eTag = "R4/R3";
      if (vld[way]) begin now++; stamp[way] = now; end
      return;
    end
    isFull = 1;
    for (int i = 0; i < 8; i++) if (!vld[i]) isFull = 0;
    migOn = (fastMask != 8'h00) && (fastMask != 8'hFF);
    if (!isFull) begin
      eTag = "R2/R1";
      tgt = -1;
      for (int i = 0; i < 8; i++) if (tgt < 0 && !vld[i] && fastMask[i]) tgt = i;
      for (int i = 0; i < 8; i++) if (tgt < 0 && !vld[i]) tgt = i;
      vld[tgt] = 1; now++; stamp[tgt] = now;
      eFill = 1; eFillWay = tgt;
      return;
    end
    vic = 0;
    for (int i = 1; i < 8; i++) if (stamp[i] < stamp[vic]) vic = i;
    eEvict = 1; eEvictWay = vic;
    if (migOn && !fastMask[vic]) begin
      q = quickOldest();
      stamp[vic] = stamp[q];
      tgt = q; eM0 = 1; eM0Src = q; eM0Dst = vic; eTag = "R6/R10";
    end else begin
      tgt = vic; eTag = migOn ? "R5/R3" : "R8/R5";
    end
    now++; stamp[tgt] = now;
    eFill = 1; eFillWay = tgt;
    if (migOn) begin
      sec = (tgt == 0) ? 1 : 0;
      for (int i = 0; i < 8; i++) if (i != tgt && stamp[i] > stamp[sec]) sec = i;
      if (!fastMask[sec]) begin
        q = quickOldest();
        if (q != tgt) begin
          t = stamp[sec]; stamp[sec] = stamp[q]; stamp[q] = t;
          eM1 = 1; eM1Src = sec; eM1Dst = q; eTag = {eTag, "/R7"};
        end
      end
    end
  endfunction

  task automatic checkResp();
    testsRun++;
    if (rspValid !== 1'b1 || fillValid !== eFill || int'(fillWay) != eFillWay ||
        evictValid !== eEvict || int'(evictWay) != eEvictWay ||
        mig0Valid !== eM0 || int'(mig0Src) != eM0Src || int'(mig0Dst) != eM0Dst ||
        mig1Valid !== eM1 || int'(mig1Src) != eM1Src || int'(mig1Dst) != eM1Dst) begin
      testsFailed++;
      $display("FAIL %s R9: got rsp=%0b fill=%0b/%0d evict=%0b/%0d m0=%0b/%0d>%0d m1=%0b/%0d>%0d expected rsp=1 fill=%0b/%0d evict=%0b/%0d m0=%0b/%0d>%0d m1=%0b/%0d>%0d",
        eTag, rspValid, fillValid, fillWay, evictValid, evictWay, mig0Valid, mig0Src, mig0Dst,
        mig1Valid, mig1Src, mig1Dst, eFill, eFillWay, eEvict, eEvictWay, eM0, eM0Src, eM0Dst,
        eM1, eM1Src, eM1Dst);
    end
  endtask

  task automatic access(bit hit, int way);
    accValid = 1; accHit = hit; hitWay = 3'(way);
    predict(hit, way);
    @(negedge clk);
    accValid = 0; accHit = 0;
    checkResp();
  endtask

  task automatic quietCheck(string tag);
    testsRun++;
    if (rspValid || fillValid || evictValid || mig0Valid || mig1Valid ||
        fillWay != 0 || evictWay != 0) begin
      testsFailed++;
      $display("FAIL %s: outputs active (rsp=%0b fill=%0b evict=%0b m0=%0b m1=%0b) expected all low",
        tag, rspValid, fillValid, evictValid, mig0Valid, mig1Valid);
    end
  endtask

  task automatic doReset(logic [7:0] m);
    fastMask = m; rstN = 0; accValid = 0; accHit = 0; hitWay = 0;
    repeat (3) @(negedge clk);
    quietCheck("R1 reset");
    rstN = 1;
    now = 0;
    for (int i = 0; i < 8; i++) begin stamp[i] = 0; vld[i] = 0; end
    @(negedge clk);
  endtask

  task automatic randomRun(int n);
    for (int k = 0; k < n; k++) access(($urandom % 10) < 6, $urandom % 8);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    doReset(8'h07);
    access(1, 5);              // R4: hit on empty way is ignored
    for (int k = 0; k < 8; k++) access(0, 0);  // R2 fill order: 0,1,2 then 3..7
    @(negedge clk);
    quietCheck("R9 idle");
    access(0, 0);              // R5 quick victim, then R7 swap
    access(1, 3);
    access(0, 0);              // R6 slow victim move
    randomRun(300);
    doReset(8'hA5); randomRun(300);
    doReset(8'h00); randomRun(250);   // R8 all slow
    doReset(8'hFF); randomRun(250);   // R8 all quick
    doReset(8'h10); randomRun(250);   // R7 single quick way: never swap out newest
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog R9: run did not complete, got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule